// File: doc/BRIEF.md
# Daisy-Chainable Serial Control Register

This block holds a 16-bit control word for a gain stage and its support functions, loaded through a four-pin serial port: an active-low select, a serial clock, a data input and a data output. The three serial inputs are brought into the block's own clock domain through synchronizers and their edges are detected there. While the select is low, each rising serial-clock edge shifts one data-input bit into a 16-bit shift register, most significant bit first. When the select returns high, the word is copied into the control register, but only if at least 16 serial clocks arrived during the transfer.

The data output is driven only while the select is low. At that point it presents the bit leaving the top of the shift register, which is the word shifted in by the previous transfer. This lets a host read back what it last wrote. It also lets devices be chained, with each data output feeding the next device's data input. The latched word is split into field outputs: an active-low servo disable, two active-high enables, a threshold select, four static general-purpose outputs and a 6-bit gain code.

The serial clock must run at most at one eighth of the block clock, so that every level is seen for several block cycles. The port has no back-pressure; a transfer is framed only by the select.

Top module: `serial_ctl_reg`

## Requirements
- R1: After reset, all word bits are zero. dc_servo_en=1, cm_servo_en=0, zc_en=0, ovr_thr_low=0, gpo=0, gain_code=0, sdo_en=0 and sdo is high impedance.
- R2: The word is shifted in MSB first. Bit 15 is the servo-disable bit, and dc_servo_en is its inverse. Bit 14 is cm_servo_en, bit 13 is zc_en, and bit 12 is ovr_thr_low (1 selects the lower threshold). Bits 11..8 are gpo[3:0], with bit 11 on gpo[3]. Bits 5..0 are gain_code.
- R3: When fewer than 16 rising serial clocks arrive during a transfer, its end leaves every field output unchanged. Outputs otherwise hold their value between loads.
- R4: When more than 16 rising serial clocks arrive, the last 16 bits shifted in are loaded.
- R5: While cs_n is high, sclk and sdi are ignored: neither the field outputs nor the shift register contents change.
- R6: sdo_en is 1 and sdo is driven only while cs_n is low; otherwise sdo is high impedance.
- R7: During a transfer, sdo shows the shift register contents MSB first. The first bit is valid after cs_n falls, and each later bit is valid after a falling sclk edge. After a full 16-bit write, the next transfer therefore reads that word back.
- R8: Bits 7..6 affect no field output, but they are read back on sdo exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high impedance when deselected |
| sdo_en | output | 1 | High while sdo is driven |
| dc_servo_en | output | 1 | Servo enable (inverse of word bit 15) |
| cm_servo_en | output | 1 | Common-mode servo enable |
| zc_en | output | 1 | Zero-cross gating enable |
| ovr_thr_low | output | 1 | Over-range threshold select, 1 = lower |
| gpo | output | 4 | Static general-purpose outputs |
| gain_code | output | 6 | Gain code |

## Verification
The hardest state to reach is a shift register that no longer matches the loaded word. This happens after a transfer too short to load, or one that overruns 16 bits. It is visible only through the data output of the following transfer. The bench keeps its own 16-bit model of the shift path. It runs a 10-bit transfer and then a 20-bit transfer, then reads back the partial contents and the loaded word through a later transfer. It also toggles sclk and sdi with the select high, then proves through a readback that the register was not disturbed.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef struct packed {
    logic       dc_off;
    logic       cm_on;
    logic       zc_on;
    logic       ovr_low;
    logic [3:0] gpo;
    logic [1:0] resv;
    logic [5:0] gain;
  } ctl_fields_t;

  localparam int CTL_W = $bits(ctl_fields_t);
  localparam int CNT_W = $clog2(CTL_W + 1);
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[k] <= RST_VAL;
          else        st[k] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[k] <= RST_VAL;
          else        st[k] <= st[k-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sclk_s,
  input  logic             sdi_s,
  output logic [CTL_W-1:0] shreg,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             sdo_bit,
  output logic             sdo_en,
  output logic             latch_pulse
);
  logic sclk_q, cs_q;
  logic rise, fall, start, stop;

  assign rise  = sclk_s & ~sclk_q;
  assign fall  = ~sclk_s & sclk_q;
  assign start = cs_act & ~cs_q;
  assign stop  = ~cs_act & cs_q;
  assign latch_pulse = stop && (bit_cnt == CNT_W'(CTL_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
      sdo_en  <= 1'b0;
      sdo_bit <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_act;
      sdo_en <= cs_act;
      if (start) begin
        bit_cnt <= '0;
        sdo_bit <= shreg[CTL_W-1];
      end else if (cs_act) begin
        if (rise) begin
          shreg <= {shreg[CTL_W-2:0], sdi_s};
          if (bit_cnt != CNT_W'(CTL_W)) bit_cnt <= bit_cnt + 1'b1;
        end
        if (fall) sdo_bit <= shreg[CTL_W-1];
      end
    end
  end
endmodule

// File: rtl/ctl_latch.sv
module ctl_latch
  import ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CTL_W-1:0] din,
  output ctl_fields_t      fields
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    fields <= '0;
    else if (load) fields <= ctl_fields_t'(din);
endmodule

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg
  import ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_en,
  output logic       dc_servo_en,
  output logic       cm_servo_en,
  output logic       zc_en,
  output logic       ovr_thr_low,
  output logic [3:0] gpo,
  output logic [5:0] gain_code
);
  logic [2:0]       pins_s;
  logic             cs_act;
  logic [CTL_W-1:0] shreg;
  logic [CNT_W-1:0] bit_cnt;
  logic             sdo_bit;
  logic             latch_pulse;
  ctl_fields_t      fields;
  logic [CTL_W-1:0] ctl_word;

  pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  assign cs_act = ~pins_s[2];

  ser_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_s(pins_s[1]),
    .sdi_s(pins_s[0]), .shreg(shreg), .bit_cnt(bit_cnt), .sdo_bit(sdo_bit),
    .sdo_en(sdo_en), .latch_pulse(latch_pulse)
  );

  ctl_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load(latch_pulse), .din(shreg), .fields(fields)
  );

  assign ctl_word    = fields;
  assign dc_servo_en = ~fields.dc_off;
  assign cm_servo_en = fields.cm_on;
  assign zc_en       = fields.zc_on;
  assign ovr_thr_low = fields.ovr_low;
  assign gpo         = fields.gpo;
  assign gain_code   = fields.gain;
  assign sdo         = sdo_en ? sdo_bit : 1'bz;
endmodule

// File: rtl/serial_ctl_reg_chk.sv
module serial_ctl_reg_chk
  import ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic [CTL_W-1:0] shreg,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             latch_pulse,
  input logic [CTL_W-1:0] ctl_word,
  input logic             sdo_en
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_pulse |=> $stable(ctl_word));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> ctl_word == $past(shreg));

  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable(shreg));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_en);

  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CTL_W));
endmodule

bind serial_ctl_reg serial_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .shreg(shreg), .bit_cnt(bit_cnt),
  .latch_pulse(latch_pulse), .ctl_word(ctl_word), .sdo_en(sdo_en)
);

// File: tb/sim_serial_ctl_reg.sv
module sim_serial_ctl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en, dc_servo_en, cm_servo_en, zc_en, ovr_thr_low;
  logic [3:0] gpo;
  logic [5:0] gain_code;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [15:0] sh_mdl = '0;
  logic [15:0] ld_mdl = '0;

  localparam int HALF = 8;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'hFFFF, 16'h0000, 16'h8A15,
                                       16'h53C0, 16'h2F3F, 16'h40C7};

  always #2 clk = ~clk;

  serial_ctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdo_en(sdo_en), .dc_servo_en(dc_servo_en), .cm_servo_en(cm_servo_en),
    .zc_en(zc_en), .ovr_thr_low(ovr_thr_low), .gpo(gpo), .gain_code(gain_code)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [13:0] fields_of(input logic [15:0] w);
    return {~w[15], w[14], w[13], w[12], w[11:8], w[5:0]};
  endfunction

  function automatic logic [13:0] outs();
    return {dc_servo_en, cm_servo_en, zc_en, ovr_thr_low, gpo, gain_code};
  endfunction

  task automatic xfer(input logic [31:0] data, input int n, output logic [15:0] rd);
    rd = '0;
    cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      wclk(HALF);
      if (i == 0) chk("R6 sdo_en during transfer", 32'(sdo_en), 32'd1);
      if (i < 16) rd[15-i] = sdo;
      sclk = 1'b1;
      sh_mdl = {sh_mdl[14:0], data[n-1-i]};
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    cs_n = 1'b1;
    if (n >= 16) ld_mdl = sh_mdl;
    wclk(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, prev;
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
    // R1 reset state
    chk("R1 fields", 32'(outs()), 32'(fields_of(16'h0000)));
    chk("R1 sdo_en", 32'(sdo_en), 32'd0);
    chk("R1 sdo hiz", 32'(sdo === 1'bz), 32'd1);

    // vector table: R2 decode, R7 readback of previous word
    for (int v = 0; v < NV; v++) begin
      prev = sh_mdl;
      xfer(32'(VEC[v]), 16, rd);
      chk($sformatf("R2 decode vec%0d", v), 32'(outs()), 32'(fields_of(VEC[v])));
      chk($sformatf("R7 readback vec%0d", v), 32'(rd), 32'(prev));
      chk("R6 sdo hiz after", 32'(sdo === 1'bz), 32'd1);
    end

    // R8: reserved bits 7..6 do not change outputs but read back
    xfer(32'h0000_A5C9, 16, rd);
    chk("R8 resv set outputs", 32'(outs()), 32'(fields_of(16'hA509)));
    xfer(32'h0000_A509, 16, rd);
    chk("R8 resv readback", 32'(rd), 32'h0000_A5C9);
    chk("R8 resv clear outputs", 32'(outs()), 32'(fields_of(16'hA5C9)));

    // R5: activity with cs_n high is ignored
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
    end
    wclk(HALF);
    chk("R5 outputs unchanged", 32'(outs()), 32'(fields_of(16'hA509)));
    chk("R6 sdo hiz while idle", 32'(sdo === 1'bz), 32'd1);
    prev = sh_mdl;
    xfer(32'h0000_1234, 16, rd);
    chk("R5 shift reg untouched", 32'(rd), 32'(prev));

    // R3: short transfer does not load
    xfer(32'h0000_02AB, 10, rd);
    chk("R3 short no load", 32'(outs()), 32'(fields_of(16'h1234)));
    prev = sh_mdl;
    xfer(32'h0000_0000, 16, rd);
    chk("R7 partial readback", 32'(rd), 32'(prev));
    chk("R3 full load after short", 32'(outs()), 32'(fields_of(16'h0000)));

    // R4: long transfer keeps the last 16 bits
    xfer(32'h000F_6E3D, 20, rd);
    chk("R4 last 16 bits", 32'(outs()), 32'(fields_of(16'h6E3D)));
    chk("R4 model agrees", 32'(ld_mdl), 32'h0000_6E3D);
    xfer(32'h0000_0000, 16, rd);
    chk("R4 readback", 32'(rd), 32'h0000_6E3D);

    // R3: hold between writes
    wclk(50);
    chk("R3 hold", 32'(outs()), 32'(fields_of(16'h0000)));

    // R1: reset mid-life
    xfer(32'h0000_7FFF, 16, rd);
    rst_n = 1'b0;
    wclk(2);
    chk("R1 reset again", 32'(outs()), 32'(fields_of(16'h0000)));
    rst_n = 1'b1;
    sh_mdl = '0;
    wclk(4);
    xfer(32'h0000_0001, 16, rd);
    chk("R1 shift reg cleared", 32'(rd), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule